// File: doc/BRIEF.md
# Watchdog Timer with Gated Reset Output

A bus-mapped watchdog that counts a programmed timeout down on an external tick and, once the count runs out, latches an expired flag and may drive a reset pulse toward the system. Software starts it by turning on the reference clock, loading the timeout, clearing any old expiry, enabling the counter, then arming the reset path. It keeps the system alive by rewriting the count register before it runs out.

The reset path has two independent gates: an enable bit in one register and a mask bit in another. The pulse reaches the pin only while the enable is set and the mask is clear. A stop sequence sets the mask first, so any pulse in progress is cut off at once. After reset the mask is set and the counter is off, so nothing can reach the pin until software arms it.

The register interface is single cycle. A write takes effect at the clock edge where `req_i` and `we_i` are high. Read data is combinational and is valid in the cycle where `req_i` is high and `we_i` is low; in all other cycles `rdata_o` is zero. The word map on `addr_i` is: 0 control, 1 status, 2 count, 3 reset enable, 4 reset mask, 5 pulse length.

Top module: `wdog_rstgate`

## Requirements
- R1: After reset, control, status, count and reset-enable read 0, reset-mask reads 0x0000_0400, pulse length reads PULSE_RST, and `reset_o` is low.
- R2: The count drops by exactly one at each edge with `tick_i` high, but only while control bit 8 (run) and control bit 10 (reference clock enable) are both set. Otherwise it holds.
- R3: A write to the count register (address 2) loads `wdata_i` and takes priority over a decrement in the same cycle. Reading address 2 returns the live count.
- R4: A decrement from 1 to 0 leaves the count at 0, where it stays, and sets status bit 31 at that same edge.
- R5: Status bit 31 is sticky. A status write with bit 31 at 0 clears it, a write with bit 31 at 1 leaves it as it was, and an expiry in the same cycle as a clear leaves it set.
- R6: An expiry loads the pulse length (address 5, low PULSE_W bits). When the gate is open, `reset_o` is then high for exactly that many cycles, starting right after the expiry edge. A length of 0 gives no pulse.
- R7: `reset_o` is low in any cycle where reset-enable bit 8 is clear or reset-mask bit 10 is set, including in the middle of a pulse.
- R8: Bits with no function in the control, status, reset-enable and reset-mask registers read back exactly as last written.
- R9: A count that reaches 0 by being written never causes an expiry, even while the timer runs. Also, a write that lands in the same cycle as the final decrement suppresses the expiry.
- R10: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-down strobe, one step per high cycle |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with req_i high and we_i low |
| reset_o | output | 1 | Gated watchdog reset pulse |

## Verification
The assertions check on every cycle that the count holds when nothing moves it, that it steps by exactly one when it does, and that zero is terminal. They also check that an expiry always leaves the sticky flag set, and that the pulse counter only ever starts from an expiry and then shrinks. Some behaviour only the bench scenarios can show:
- the exact pulse length at the pin and its cut-off when the mask is set partway through;
- the read-back of unused bits;
- the priority of a count write over a final decrement;
- the ordered start and stop sequences.

A seeded random phase compares every read and every cycle of `reset_o` against a bench model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RSTEN = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PLEN  = 3'd5;

  localparam int B_RUN   = 8;
  localparam int B_CLKEN = 10;
  localparam int B_EXP   = 31;
  localparam int B_RSTEN = 8;
  localparam int B_MASK  = 10;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign dec      = run_i && tick_i && (cnt_q != '0);
  // a reload in the same cycle as the final step wins and suppresses expiry
  assign expire_o = dec && (cnt_q == ONE) && !ld_i;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (dec)   cnt_q <= cnt_q - ONE;
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && tick_i) && !ld_i) |=> $stable(cnt_o));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !ld_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - ONE));
  a_r4_zero_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !ld_i) |=> (cnt_o == '0));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               expire_i,
  input  logic [PULSE_W-1:0] len_i,
  input  logic               gate_i,
  output logic               reset_o
);
  logic [PULSE_W-1:0] pcnt_q;
  logic               active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pcnt_q <= '0;
    else if (expire_i)    pcnt_q <= len_i;
    else if (pcnt_q != '0) pcnt_q <= pcnt_q - PULSE_W'(1);
  end

  assign active  = (pcnt_q != '0);
  // gate applied live so masking kills a running pulse at once
  assign reset_o = active && gate_i;

  a_r6_starts_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active) |-> $past(expire_i));
  a_r6_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !expire_i) |=> (pcnt_q < $past(pcnt_q)));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_W   = 8,
  parameter int PULSE_RST = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               expire_i,
  output logic               cnt_ld_o,
  output logic               run_o,
  output logic               gate_o,
  output logic [PULSE_W-1:0] plen_o
);
  localparam logic [DATA_W-1:0] MASK_RST = DATA_W'(1) << B_MASK;

  logic               wr;
  logic [DATA_W-1:0]  ctrl_q, stat_q, rsten_q, mask_q;
  logic [PULSE_W-1:0] plen_q;
  logic [DATA_W-1:0]  cnt_ext, plen_ext, rd_mux;
  logic               stat_clr;

  assign wr       = req_i && we_i;
  assign cnt_ld_o = wr && (addr_i == A_CNT);
  assign stat_clr = wr && (addr_i == A_STAT) && !wdata_i[B_EXP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      rsten_q <= '0;
      mask_q  <= MASK_RST;
      plen_q  <= PULSE_W'(PULSE_RST);
    end else begin
      if (wr) begin
        case (addr_i)
          A_CTRL:  ctrl_q  <= wdata_i;
          A_STAT:  stat_q  <= {stat_q[B_EXP] & wdata_i[B_EXP], wdata_i[B_EXP-1:0]};
          A_RSTEN: rsten_q <= wdata_i;
          A_MASK:  mask_q  <= wdata_i;
          A_PLEN:  plen_q  <= wdata_i[PULSE_W-1:0];
          default: ;
        endcase
      end
      if (expire_i) stat_q[B_EXP] <= 1'b1;
    end
  end

  always_comb begin
    cnt_ext  = '0;
    cnt_ext[CNT_W-1:0] = cnt_i;
    plen_ext = '0;
    plen_ext[PULSE_W-1:0] = plen_q;
    case (addr_i)
      A_CTRL:  rd_mux = ctrl_q;
      A_STAT:  rd_mux = stat_q;
      A_CNT:   rd_mux = cnt_ext;
      A_RSTEN: rd_mux = rsten_q;
      A_MASK:  rd_mux = mask_q;
      A_PLEN:  rd_mux = plen_ext;
      default: rd_mux = '0;
    endcase
  end

  assign rdata_o = (req_i && !we_i) ? rd_mux : '0;
  assign run_o   = ctrl_q[B_RUN] && ctrl_q[B_CLKEN];
  assign gate_o  = rsten_q[B_RSTEN] && !mask_q[B_MASK];
  assign plen_o  = plen_q;

  a_r4_expiry_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> stat_q[B_EXP]);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[B_EXP] && !stat_clr) |=> stat_q[B_EXP]);
endmodule

// File: rtl/wdog_rstgate.sv
module wdog_rstgate
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_W   = 8,
  parameter int PULSE_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reset_o
);
  logic [CNT_W-1:0]   cnt;
  logic               expire, cnt_ld, run, gate;
  logic [PULSE_W-1:0] plen;

  wdog_regs #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .PULSE_RST(PULSE_RST)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .expire_i(expire), .cnt_ld_o(cnt_ld), .run_o(run),
    .gate_o(gate), .plen_o(plen)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .tick_i, .ld_i(cnt_ld),
    .ld_val_i(wdata_i[CNT_W-1:0]), .cnt_o(cnt), .expire_o(expire)
  );

  wdog_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk_i, .rst_ni, .expire_i(expire), .len_i(plen), .gate_i(gate),
    .reset_o
  );

  a_r9_expiry_needs_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> (run && tick_i && !cnt_ld));
endmodule

// File: tb/sim_wdog_rstgate.sv
module sim_wdog_rstgate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        reset_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam int PRST = 4;

  wdog_rstgate #(.CNT_W(32), .PULSE_W(8), .PULSE_RST(PRST)) u0 (.*);

  always #5 clk_i = ~clk_i;

  // bench model
  logic [31:0] m_ctrl, m_stat, m_cnt, m_rsten, m_mask;
  logic [7:0]  m_plen, m_pcnt;

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_stat;
      3'd2: return m_cnt;
      3'd3: return m_rsten;
      3'd4: return m_mask;
      3'd5: return {24'd0, m_plen};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_rst();
    return (m_pcnt != 0) && m_rsten[8] && !m_mask[10];
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd1: return "R5";
      3'd2: return "R3";
      3'd5: return "R6";
      3'd6, 3'd7: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check, advance model, wait next negedge
  task automatic step(input logic rq, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input logic tk, input string tag);
    logic run, dec, ld, expv;
    logic [31:0] n_stat;
    req_i = rq; we_i = w; addr_i = a; wdata_i = d; tick_i = tk;
    #1;
    if (rq && !w) check((tag == "") ? tag_of(a) : tag, rdata_o, exp_rd(a));
    check((tag == "") ? "R7" : tag, {31'd0, reset_o}, {31'd0, exp_rst()});
    run  = m_ctrl[8] && m_ctrl[10];
    dec  = run && tk && (m_cnt != 0);
    ld   = rq && w && (a == 3'd2);
    expv = dec && (m_cnt == 1) && !ld;
    n_stat = m_stat;
    if (rq && w && a == 3'd1) n_stat = {m_stat[31] & d[31], d[30:0]};
    if (expv) n_stat[31] = 1'b1;
    @(posedge clk_i);
    m_stat = n_stat;
    m_pcnt = expv ? m_plen : (m_pcnt != 0 ? m_pcnt - 8'd1 : 8'd0);
    if (ld) m_cnt = d; else if (dec) m_cnt = m_cnt - 1;
    if (rq && w) begin
      case (a)
        3'd0: m_ctrl  = d;
        3'd3: m_rsten = d;
        3'd4: m_mask  = d;
        3'd5: m_plen  = d[7:0];
        default: ;
      endcase
    end
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 1'b0, "");
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, 1'b0, tag);
  endtask
  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 32'd0, 1'b1, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 32'd0, 1'b0, tag);
  endtask

  initial begin
    int hi;
    m_ctrl = 0; m_stat = 0; m_cnt = 0; m_rsten = 0; m_mask = 32'h400;
    m_plen = PRST; m_pcnt = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");
    check("R1", {31'd0, reset_o}, 32'd0);

    // R2 clock enable missing: no decrement
    wr(3'd2, 32'd5);
    wr(3'd0, 32'h0000_0100);
    ticks(3, "R2");
    rd(3'd2, "R2");
    check("R2", exp_rd(3'd2), 32'd5);
    wr(3'd0, 32'h0000_0500);
    ticks(2, "R2");
    idle(2, "R2");
    rd(3'd2, "R2");
    check("R2", rdata_o, 32'd3);

    // start sequence, R4 and R6
    wr(3'd5, 32'd3);
    wr(3'd2, 32'd2);
    wr(3'd1, 32'd0);
    wr(3'd3, 32'h100);
    wr(3'd4, 32'd0);
    ticks(2, "R4");
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      if (reset_o) hi++;
      idle(1, "R6");
    end
    check("R6", hi, 3);
    rd(3'd1, "R4");
    check("R4", rdata_o[31], 1);
    ticks(3, "R4");
    rd(3'd2, "R4");

    // R5 sticky, R8 other bits
    wr(3'd1, 32'h8000_0000);
    rd(3'd1, "R5");
    check("R5", rdata_o, 32'h8000_0000);
    wr(3'd1, 32'h0000_1234);
    rd(3'd1, "R5");
    check("R8", rdata_o, 32'h0000_1234);
    wr(3'd0, 32'hA5A5_05A5);
    rd(3'd0, "R8");
    check("R8", rdata_o, 32'hA5A5_05A5);
    wr(3'd0, 32'h0000_0500);

    // R7 mask set: expiry flagged but pin quiet
    wr(3'd4, 32'h400);
    wr(3'd2, 32'd1);
    ticks(1, "R7");
    idle(4, "R7");
    rd(3'd1, "R7");
    // R7 mask mid-pulse cuts the pin
    wr(3'd1, 32'd0);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd6);
    wr(3'd2, 32'd1);
    ticks(1, "R6");
    idle(1, "R6");
    wr(3'd4, 32'h400);
    check("R7", {31'd0, reset_o}, 32'd0);
    idle(6, "R7");

    // R9 write to zero with timer running
    wr(3'd4, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    ticks(4, "R9");
    rd(3'd1, "R9");
    check("R9", rdata_o, 32'd0);
    // R3 / R9 reload beats last step
    wr(3'd2, 32'd1);
    step(1'b1, 1'b1, 3'd2, 32'd7, 1'b1, "R3");
    rd(3'd2, "R3");
    check("R3", rdata_o, 32'd7);
    rd(3'd1, "R9");
    check("R9", rdata_o, 32'd0);

    // R6 zero length: no pulse
    wr(3'd5, 32'd0);
    wr(3'd2, 32'd1);
    ticks(1, "R6");
    hi = 0;
    for (int i = 0; i < 4; i++) begin
      if (reset_o) hi++;
      idle(1, "R6");
    end
    check("R6", hi, 0);

    // R10 unmapped
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, "R10");
    rd(3'd7, "R10");
    for (int a = 0; a < 6; a++) rd(3'(a), "R10");

    // stop sequence: mask, disable reset, stop timer
    wr(3'd4, 32'h400);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd0);
    ticks(3, "R2");

    // seeded random phase
    for (int i = 0; i < 4000; i++) begin
      logic rq, w, tk;
      logic [2:0] a;
      logic [31:0] d;
      rq = ($urandom % 2) == 0;
      w  = ($urandom % 2) == 0;
      a  = 3'($urandom % 8);
      tk = ($urandom % 5) < 2;
      d  = $urandom;
      case (a)
        3'd0: if ($urandom % 4 != 0) d = d | 32'h500;
        3'd1: if ($urandom % 2 == 0) d[31] = 1'b0;
        3'd2: d = $urandom % 8;
        3'd4: d[10] = ($urandom % 3) == 0;
        3'd5: d = $urandom % 6;
        default: ;
      endcase
      step(rq, w, a, d, tk, "");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule